// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-state controller of a small 16-bit microcontroller. Software requests a sleep level by placing a 3-bit mode code on a request port for one cycle. The block then drops the CPU and master clock. Each remaining clock enable, memory gate and the core-supply enable follows a pattern fixed for that level. Optional clocks stay on only while their keep bit is set. The block watches the wake inputs allowed for the current level: any interrupt line, the I/O wake line and the RTC counter wake line. It runs a per-level wake-up countdown and then gives the clock back to the CPU.

For the two shallow levels, a wake runs as an interrupt. When the service routine signals return from interrupt, the block goes back to the level it left, unless software changed the return level while in the routine. A wake from the deepest levels, the ones that cut the core supply, is a restart. A core reset is held for the whole countdown, and a sticky flag shows which of the two levels was left. A wake from the all-clocks-off level leaves the device running.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset the block is running: cur_mode_o=0, waking_o=0, cpu, master clock, program memory, RAM, backup and core supply enabled, core_rst_o=0, both flags 0, and subsystem, auxiliary, FLL/DCO and low-frequency oscillator enables equal clk_keep_i bits 0, 1, 2, 3. Whenever cpu_en_o is high, memories and core supply are on and core_rst_o is low.
- R2: While running outside an interrupt, a request with code 1 (LPM0), 2 (LPM3), 3 (LPM4), 4 (LPM3.5) or 5 (LPM4.5) enters that level at the next edge. Code 0 and reserved codes 6 and 7 leave the block running.
- R3: In LPM0, the CPU and master clock are off. Subsystem, auxiliary, FLL/DCO and low-frequency enables follow their keep bits. Program memory, RAM, backup and supply are on.
- R4: In LPM3, the master clock, subsystem clock, FLL/DCO, CPU and program memory are off. Auxiliary and low-frequency enables follow their keep bits. RAM, backup and supply are on.
- R5: In LPM4, every clock enable, the CPU and program memory are off. RAM, backup and supply stay on.
- R6: In LPM3.5, only the low-frequency enable (following keep bit 3) and backup memory stay on. In LPM4.5, every clock and memory is off. Both levels drop core_pwr_en_o.
- R7: Permitted wake sources are: any irq_i bit, io_wake_i or rtc_wake_i in LPM0 and LPM3; io_wake_i only in LPM4 and LPM4.5; io_wake_i or rtc_wake_i in LPM3.5. Any other event leaves the state unchanged.
- R8: After a permitted wake, waking_o stays high for exactly the level's latency in cycles: WAKE_LAT_LPM0 for LPM0, WAKE_LAT_LPM34 for LPM3/LPM4, WAKE_LAT_X5 for LPM3.5/LPM4.5. The CPU and master clock stay off during this time and come back in the next cycle. A zero latency runs the CPU at the next edge.
- R9: A wake from LPM0 or LPM3 starts an interrupt. reti_i then returns to that level at the next edge. A request taken during the interrupt replaces the return level, and code 0 or a reserved code means stay running. reti_i outside an interrupt, including after an LPM4 wake, has no effect.
- R10: During the countdown from LPM3.5 or LPM4.5, core_pwr_en_o and core_rst_o are high. The countdown ends in the running state with no interrupt. x35_wake_flag_o or x45_wake_flag_o is set when that wake starts and stays set until rst_ni.
- R11: A request arriving during a countdown is held, with the latest one kept. It is applied in the first running cycle. A held request is dropped when the countdown came from LPM3.5 or LPM4.5.
- R12: Mode requests while asleep, outside a countdown, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_valid_i | input | 1 | One-cycle mode request strobe |
| mode_req_i | input | 3 | Requested mode code |
| clk_keep_i | input | 4 | Keep bits: subsystem, auxiliary, FLL/DCO, low-frequency oscillators |
| irq_i | input | NUM_IRQ | Per-source interrupt lines |
| io_wake_i | input | 1 | I/O wake event |
| rtc_wake_i | input | 1 | RTC counter wake event |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mclk_en_o | output | 1 | Master clock enable |
| smclk_en_o | output | 1 | Subsystem clock enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| fll_en_o | output | 1 | FLL/DCO/modulation clock enable |
| lfosc_en_o | output | 1 | Low-frequency oscillator enable |
| cpu_en_o | output | 1 | CPU gate |
| pmem_en_o | output | 1 | Program memory gate |
| ram_en_o | output | 1 | RAM gate |
| bkup_en_o | output | 1 | Backup register gate |
| core_pwr_en_o | output | 1 | Core supply enable |
| core_rst_o | output | 1 | Core reset during restart countdown |
| x35_wake_flag_o | output | 1 | Sticky: woke from LPM3.5 |
| x45_wake_flag_o | output | 1 | Sticky: woke from LPM4.5 |
| waking_o | output | 1 | Wake countdown in progress |
| cur_mode_o | output | 3 | Current sleep level, 0 while running |

## Verification
A wrong phase or mode register shows up in the cycle after the faulty edge. Either cur_mode_o and the whole gate pattern switch to another level, or waking_o rises or falls at the wrong time. A lost interrupt bit or return level stays hidden until reti_i arrives, and then the block fails to return to sleep. A miscounted countdown is visible only at its end, as cpu_en_o rising one or more cycles early or late. A lost or wrongly dropped held request appears one cycle after the countdown ends. The reference model compares every output on every cycle, so each of these faults is caught at the first cycle where it reaches a port.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int KEEP_W = 4;

  typedef enum logic [2:0] {
    M_ACT   = 3'd0,
    M_LPM0  = 3'd1,
    M_LPM3  = 3'd2,
    M_LPM4  = 3'd3,
    M_LPM35 = 3'd4,
    M_LPM45 = 3'd5
  } lpm_mode_e;

  typedef enum logic [1:0] {
    PH_ACT   = 2'd0,
    PH_SLEEP = 2'd1,
    PH_WAKE  = 2'd2
  } lpm_phase_e;

  typedef struct packed {
    logic mclk;
    logic smclk;
    logic aclk;
    logic fll;
    logic lfosc;
    logic cpu;
    logic pmem;
    logic ram;
    logic bkup;
    logic pwr;
  } lpm_gate_t;

  function automatic lpm_mode_e lpm_decode(input logic [2:0] code);
    case (code)
      3'd1:    return M_LPM0;
      3'd2:    return M_LPM3;
      3'd3:    return M_LPM4;
      3'd4:    return M_LPM35;
      3'd5:    return M_LPM45;
      default: return M_ACT;
    endcase
  endfunction
endpackage

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  lpm_mode_e          mode_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               io_i,
  input  logic               rtc_i,
  output logic               wake_o
);
  logic irq_any;
  assign irq_any = |irq_i;

  always_comb begin
    case (mode_i)
      M_LPM0, M_LPM3:   wake_o = irq_any | io_i | rtc_i;
      M_LPM4, M_LPM45:  wake_o = io_i;
      M_LPM35:          wake_o = io_i | rtc_i;
      default:          wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
  import lpm_pkg::*;
(
  input  lpm_phase_e        phase_i,
  input  lpm_mode_e         mode_i,
  input  logic [KEEP_W-1:0] keep_i,
  output lpm_gate_t         gate_o,
  output logic              rst_o
);
  always_comb begin
    gate_o = '0;
    rst_o  = 1'b0;
    if (phase_i == PH_ACT) begin
      gate_o.mclk  = 1'b1;
      gate_o.smclk = keep_i[0];
      gate_o.aclk  = keep_i[1];
      gate_o.fll   = keep_i[2];
      gate_o.lfosc = keep_i[3];
      gate_o.cpu   = 1'b1;
      gate_o.pmem  = 1'b1;
      gate_o.ram   = 1'b1;
      gate_o.bkup  = 1'b1;
      gate_o.pwr   = 1'b1;
    end else begin
      case (mode_i)
        M_LPM0: begin
          gate_o.smclk = keep_i[0];
          gate_o.aclk  = keep_i[1];
          gate_o.fll   = keep_i[2];
          gate_o.lfosc = keep_i[3];
          gate_o.pmem  = 1'b1;
          gate_o.ram   = 1'b1;
          gate_o.bkup  = 1'b1;
          gate_o.pwr   = 1'b1;
        end
        M_LPM3: begin
          gate_o.aclk  = keep_i[1];
          gate_o.lfosc = keep_i[3];
          gate_o.ram   = 1'b1;
          gate_o.bkup  = 1'b1;
          gate_o.pwr   = 1'b1;
        end
        M_LPM4: begin
          gate_o.ram   = 1'b1;
          gate_o.bkup  = 1'b1;
          gate_o.pwr   = 1'b1;
        end
        M_LPM35: begin
          gate_o.lfosc = keep_i[3];
          gate_o.bkup  = 1'b1;
        end
        default: ;
      endcase
      // restart path: supply returns, core held in reset for the countdown
      if (phase_i == PH_WAKE) begin
        gate_o.pwr = 1'b1;
        rst_o      = (mode_i == M_LPM35) || (mode_i == M_LPM45);
      end
    end
  end
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ        = 4,
  parameter int WAKE_LAT_LPM0  = 0,
  parameter int WAKE_LAT_LPM34 = 10,
  parameter int WAKE_LAT_X5    = 150
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_req_valid_i,
  input  logic [2:0]         mode_req_i,
  input  logic [3:0]         clk_keep_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               io_wake_i,
  input  logic               rtc_wake_i,
  input  logic               reti_i,
  output logic               mclk_en_o,
  output logic               smclk_en_o,
  output logic               aclk_en_o,
  output logic               fll_en_o,
  output logic               lfosc_en_o,
  output logic               cpu_en_o,
  output logic               pmem_en_o,
  output logic               ram_en_o,
  output logic               bkup_en_o,
  output logic               core_pwr_en_o,
  output logic               core_rst_o,
  output logic               x35_wake_flag_o,
  output logic               x45_wake_flag_o,
  output logic               waking_o,
  output logic [2:0]         cur_mode_o
);
  localparam int LAT_A   = (WAKE_LAT_LPM0 > WAKE_LAT_LPM34) ? WAKE_LAT_LPM0 : WAKE_LAT_LPM34;
  localparam int LAT_MAX = (LAT_A > WAKE_LAT_X5) ? LAT_A : WAKE_LAT_X5;
  localparam int CNT_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  lpm_phase_e       phase_q;
  lpm_mode_e        mode_q, ret_q, pend_m_q;
  logic             isr_q, pend_v_q, x35_q, x45_q;
  logic             wake_ok, lat_zero, tmr_load, tmr_done, finish;
  logic [CNT_W-1:0] lat_m1;
  logic             eff_v;
  lpm_mode_e        eff_m, ret_n;
  lpm_gate_t        gate;
  logic             gate_rst;

  lpm_wake_filter #(.NUM_IRQ(NUM_IRQ)) u_filter (
    .mode_i (mode_q),
    .irq_i  (irq_i),
    .io_i   (io_wake_i),
    .rtc_i  (rtc_wake_i),
    .wake_o (wake_ok)
  );

  always_comb begin
    case (mode_q)
      M_LPM0: begin
        lat_zero = (WAKE_LAT_LPM0 == 0);
        lat_m1   = CNT_W'(WAKE_LAT_LPM0 - 1);
      end
      M_LPM3, M_LPM4: begin
        lat_zero = (WAKE_LAT_LPM34 == 0);
        lat_m1   = CNT_W'(WAKE_LAT_LPM34 - 1);
      end
      default: begin
        lat_zero = (WAKE_LAT_X5 == 0);
        lat_m1   = CNT_W'(WAKE_LAT_X5 - 1);
      end
    endcase
  end

  assign tmr_load = (phase_q == PH_SLEEP) && wake_ok && !lat_zero;

  lpm_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (lat_m1),
    .run_i      (phase_q == PH_WAKE),
    .done_o     (tmr_done)
  );

  assign finish = ((phase_q == PH_SLEEP) && wake_ok && lat_zero) ||
                  ((phase_q == PH_WAKE) && tmr_done);

  // a fresh request overrides one held over from the countdown
  assign eff_v = mode_req_valid_i | pend_v_q;
  assign eff_m = mode_req_valid_i ? lpm_decode(mode_req_i) : pend_m_q;
  assign ret_n = eff_v ? eff_m : ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_ACT;
      mode_q   <= M_ACT;
      ret_q    <= M_ACT;
      pend_m_q <= M_ACT;
      isr_q    <= 1'b0;
      pend_v_q <= 1'b0;
      x35_q    <= 1'b0;
      x45_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_ACT: begin
          pend_v_q <= 1'b0;
          if (isr_q) begin
            ret_q <= ret_n;
            if (reti_i) begin
              isr_q <= 1'b0;
              if (ret_n != M_ACT) begin
                phase_q <= PH_SLEEP;
                mode_q  <= ret_n;
              end
            end
          end else if (eff_v && eff_m != M_ACT) begin
            phase_q <= PH_SLEEP;
            mode_q  <= eff_m;
          end
        end
        PH_SLEEP: begin
          if (wake_ok) begin
            if (mode_q == M_LPM35) x35_q <= 1'b1;
            if (mode_q == M_LPM45) x45_q <= 1'b1;
            if (!lat_zero) phase_q <= PH_WAKE;
          end
        end
        PH_WAKE: begin
          if (mode_req_valid_i) begin
            pend_v_q <= 1'b1;
            pend_m_q <= lpm_decode(mode_req_i);
          end
        end
        default: phase_q <= PH_ACT;
      endcase
      if (finish) begin
        phase_q <= PH_ACT;
        isr_q   <= (mode_q == M_LPM0) || (mode_q == M_LPM3);
        ret_q   <= mode_q;
        if (mode_q == M_LPM35 || mode_q == M_LPM45) pend_v_q <= 1'b0;
      end
    end
  end

  lpm_gate_dec u_dec (
    .phase_i (phase_q),
    .mode_i  (mode_q),
    .keep_i  (clk_keep_i),
    .gate_o  (gate),
    .rst_o   (gate_rst)
  );

  assign mclk_en_o       = gate.mclk;
  assign smclk_en_o      = gate.smclk;
  assign aclk_en_o       = gate.aclk;
  assign fll_en_o        = gate.fll;
  assign lfosc_en_o      = gate.lfosc;
  assign cpu_en_o        = gate.cpu;
  assign pmem_en_o       = gate.pmem;
  assign ram_en_o        = gate.ram;
  assign bkup_en_o       = gate.bkup;
  assign core_pwr_en_o   = gate.pwr;
  assign core_rst_o      = gate_rst;
  assign x35_wake_flag_o = x35_q;
  assign x45_wake_flag_o = x45_q;
  assign waking_o        = (phase_q == PH_WAKE);
  assign cur_mode_o      = (phase_q == PH_ACT) ? 3'd0 : mode_q;
endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
module lpm_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       io_wake_i,
  input logic       mclk_en_o,
  input logic       smclk_en_o,
  input logic       cpu_en_o,
  input logic       pmem_en_o,
  input logic       ram_en_o,
  input logic       bkup_en_o,
  input logic       core_pwr_en_o,
  input logic       core_rst_o,
  input logic       x35_wake_flag_o,
  input logic       x45_wake_flag_o,
  input logic       waking_o,
  input logic [2:0] cur_mode_o
);
  p_cpu_power_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> (pmem_en_o && ram_en_o && core_pwr_en_o && !core_rst_o));

  p_lpm3_gates_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode_o == 3'd2) |-> (!pmem_en_o && !smclk_en_o && !mclk_en_o));

  p_shutdown_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode_o == 3'd5 && !waking_o) |-> (!core_pwr_en_o && !bkup_en_o && !ram_en_o));

  p_lpm4_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode_o == 3'd3 && !waking_o && !io_wake_i) |=> (cur_mode_o == 3'd3 && !waking_o));

  p_wake_cpu_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waking_o |-> (!cpu_en_o && !mclk_en_o));

  p_rst_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (waking_o && cur_mode_o >= 3'd4 && core_pwr_en_o));

  p_flag35_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x35_wake_flag_o |=> x35_wake_flag_o);

  p_flag45_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x45_wake_flag_o |=> x45_wake_flag_o);
endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .io_wake_i       (io_wake_i),
  .mclk_en_o       (mclk_en_o),
  .smclk_en_o      (smclk_en_o),
  .cpu_en_o        (cpu_en_o),
  .pmem_en_o       (pmem_en_o),
  .ram_en_o        (ram_en_o),
  .bkup_en_o       (bkup_en_o),
  .core_pwr_en_o   (core_pwr_en_o),
  .core_rst_o      (core_rst_o),
  .x35_wake_flag_o (x35_wake_flag_o),
  .x45_wake_flag_o (x45_wake_flag_o),
  .waking_o        (waking_o),
  .cur_mode_o      (cur_mode_o)
);

// File: tb/lpm_seq_ctrl_tb.sv
module lpm_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 4;
  localparam int LAT0       = 0;
  localparam int LAT34      = 10;
  localparam int LATX5      = 150;
  localparam int WD_CYCLES  = 20000;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_v = 1'b0;
  logic [2:0]         req_m = 3'd0;
  logic [3:0]         keep = 4'b0000;
  logic [NUM_IRQ-1:0] irq = '0;
  logic               io = 1'b0;
  logic               rtc = 1'b0;
  logic               reti = 1'b0;

  logic mclk, smclk, aclk, fll, lfosc, cpu, pmem, ram, bkup, pwr, crst, f35o, f45o, wk;
  logic [2:0] cmode;

  lpm_seq_ctrl #(
    .NUM_IRQ(NUM_IRQ), .WAKE_LAT_LPM0(LAT0), .WAKE_LAT_LPM34(LAT34), .WAKE_LAT_X5(LATX5)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_req_valid_i(req_v), .mode_req_i(req_m),
    .clk_keep_i(keep), .irq_i(irq), .io_wake_i(io), .rtc_wake_i(rtc), .reti_i(reti),
    .mclk_en_o(mclk), .smclk_en_o(smclk), .aclk_en_o(aclk), .fll_en_o(fll),
    .lfosc_en_o(lfosc), .cpu_en_o(cpu), .pmem_en_o(pmem), .ram_en_o(ram),
    .bkup_en_o(bkup), .core_pwr_en_o(pwr), .core_rst_o(crst),
    .x35_wake_flag_o(f35o), .x45_wake_flag_o(f45o), .waking_o(wk), .cur_mode_o(cmode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: ph 0 running, 1 asleep, 2 counting down
  int ph, md, cnt, ret, pm;
  bit isr, pv, f35, f45;
  int checks = 0;
  int failures = 0;
  string tag = "R1";

  function automatic int dec(input int c);
    return (c >= 1 && c <= 5) ? c : 0;
  endfunction

  function automatic int lat_of(input int m);
    if (m == 1) return LAT0;
    if (m == 2 || m == 3) return LAT34;
    return LATX5;
  endfunction

  function automatic bit allowed(input int m);
    case (m)
      1, 2:    return (|irq) || io || rtc;
      3, 5:    return io;
      4:       return io || rtc;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    ph = 0; md = 0; cnt = 0; ret = 0; pm = 0; isr = 0; pv = 0; f35 = 0; f45 = 0;
  endtask

  task automatic model_finish();
    ph = 0;
    isr = (md == 1 || md == 2);
    if (isr) ret = md;
    if (md >= 4) pv = 0;
  endtask

  task automatic model_step();
    bit ev;
    int em;
    ev = req_v || pv;
    em = req_v ? dec(req_m) : pm;
    if (ph == 0) begin
      pv = 0;
      if (isr) begin
        if (ev) ret = em;
        if (reti) begin
          isr = 0;
          if (ret != 0) begin ph = 1; md = ret; end
        end
      end else if (ev && em != 0) begin
        ph = 1; md = em;
      end
    end else if (ph == 1) begin
      if (allowed(md)) begin
        if (md == 4) f35 = 1;
        if (md == 5) f45 = 1;
        if (lat_of(md) == 0) model_finish();
        else begin ph = 2; cnt = lat_of(md); end
      end
    end else begin
      if (req_v) begin pv = 1; pm = dec(req_m); end
      cnt--;
      if (cnt == 0) model_finish();
    end
  endtask

  function automatic logic [16:0] expect_vec();
    logic [9:0] g;
    logic r;
    g = '0;
    r = 1'b0;
    if (ph == 0) g = {1'b1, keep[0], keep[1], keep[2], keep[3], 5'b11111};
    else begin
      case (md)
        1: g = {1'b0, keep[0], keep[1], keep[2], keep[3], 1'b0, 4'b1111};
        2: g = {1'b0, 1'b0, keep[1], 1'b0, keep[3], 1'b0, 4'b0111};
        3: g = {5'b00000, 1'b0, 4'b0111};
        4: g = {4'b0000, keep[3], 1'b0, 4'b0010};
        default: g = '0;
      endcase
      if (ph == 2) begin
        g[0] = 1'b1;
        r = (md >= 4);
      end
    end
    return {g, r, f35, f45, (ph == 2), (ph == 0) ? 3'd0 : 3'(md)};
  endfunction

  task automatic compare();
    logic [16:0] act, exp;
    act = {mclk, smclk, aclk, fll, lfosc, cpu, pmem, ram, bkup, pwr, crst, f35o, f45o, wk, cmode};
    exp = expect_vec();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    req_v = 1'b0; irq = '0; io = 1'b0; rtc = 1'b0; reti = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic req(input int m);
    req_v = 1'b1; req_m = 3'(m); tick();
  endtask

  task automatic run_all();
    // R1: reset state
    tag = "R1"; keep = 4'b1010;
    model_reset();
    repeat (2) @(negedge clk);
    compare();
    rst_ni = 1'b1;
    ticks(2);
    // R2: code 0 and reserved codes keep running; code 1 enters LPM0
    tag = "R2"; req(0); req(6); req(7); tick(); req(1);
    tag = "R3"; tick(); keep = 4'b0101; tick(); keep = 4'b1111; tick();
    tag = "R12"; req(3); tick(); req(0); tick();
    tag = "R8"; irq = 4'b0100; tick(); tick();
    tag = "R9"; req(2); reti = 1'b1; tick();
    tag = "R4"; ticks(2); keep = 4'b0010; tick();
    tag = "R8"; rtc = 1'b1; tick(); ticks(12);
    tag = "R9"; req(0); reti = 1'b1; tick(); tick(); reti = 1'b1; tick();
    tag = "R5"; req(3); tick();
    tag = "R7"; irq = 4'hF; tick(); rtc = 1'b1; tick(); tick();
    tag = "R11"; io = 1'b1; tick(); ticks(2); req(2); tick(); req(3); ticks(8);
    tag = "R5"; ticks(2); io = 1'b1; tick(); ticks(12);
    tag = "R9"; reti = 1'b1; tick(); tick();
    tag = "R6"; keep = 4'b1000; req(4); tick();
    tag = "R7"; irq = 4'h1; tick(); tick();
    tag = "R10"; rtc = 1'b1; tick(); ticks(20);
    tag = "R11"; req(1); ticks(135);
    tag = "R10"; ticks(3);
    tag = "R6"; req(5); tick();
    tag = "R7"; rtc = 1'b1; tick(); irq = 4'h2; tick();
    tag = "R10"; io = 1'b1; tick(); ticks(155);
    tag = "R11"; req(2); io = 1'b1; tick(); tick(); req(4); req(1); ticks(10);
    tag = "R9"; reti = 1'b1; tick(); ticks(2);
    // R1: asynchronous reset while asleep
    tag = "R1";
    rst_ni = 1'b0;
    #1 model_reset();
    compare();
    @(negedge clk);
    rst_ni = 1'b1;
    ticks(2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule